// File: doc/BRIEF.md
# Peripheral Bus Width-Splitting Decoder

This block sits between a 32-bit CPU register bus and the peripheral register space. It clears the top three address bits, then steers each request to one of three targets: a sound-unit port that understands only halfword registers, a timer port covering three 16-bit counter slots, or a small local register store that takes every address nobody else claims. Both sides use a valid/ready handshake. The request carries a width code: 0 = byte, 1 = halfword, 2 = word. Write data and read data are right-aligned, so a byte sits in bits 7:0 and a halfword in bits 15:0.

For the sound window the block converts widths. A word access becomes two halfword transactions: the low half at the address first, then the high half at the address plus 2. The CPU-side ready stays low until the second transaction completes. Byte writes are forwarded as zero-extended halfword writes only at even addresses. Byte writes at odd addresses are dropped and acknowledged at once. A byte read fetches the containing halfword and returns the addressed byte. Timer count and target writes are cut to 16 bits, while the mode register receives the full word. The local store holds its contents little-endian and is read and written at the requested width.

Top module: `periph_width_bridge`

## Requirements
- R1: Address bits 31:29 are ignored. Every decode and every forwarded address uses the address with those bits cleared.
- R2: The sound window covers masked addresses from 0x1F801C00 up to 0x1F801FFF inclusive. 0x1F801BFE and 0x1F802000 are outside it and go to the local store.
- R3: A word write into the sound window produces exactly two halfword transactions, in this order: `c_wdata[15:0]` at the address, then `c_wdata[31:16]` at the address plus 2.
- R4: A word read from the sound window returns the first halfword transaction's data in bits 15:0 and the second transaction's data in bits 31:16.
- R5: While a split or forwarded sound transaction waits on `s_ready`, and until the second half of a word access completes, `c_ready` stays low.
- R6: A byte write to an even sound address is sent as one halfword write carrying `{8'h00, byte}`. A byte write to an odd sound address produces no sound transaction and completes at once. A byte read returns the addressed byte of the fetched halfword, zero-extended.
- R7: Halfword and word accesses at masked addresses 0x1F801100 + 16*n + k, with n in 0..2 and k in {0,4,8}, go to the timer port with `t_idx`=n and `t_reg`=k/4 (0 count, 1 mode, 2 target). Any other offset, and any byte access, goes to the local store.
- R8: Timer writes to count or target carry `{16'h0, c_wdata[15:0]}`. Mode writes carry the full `c_wdata`.
- R9: Unclaimed addresses access a local word store indexed by address bits 7:2, with byte k of a word in bits 8k+7:8k. Byte and halfword writes change only their own lanes, and reads return the addressed lanes right-aligned.
- R10: After reset the local store reads as zero. No port issues a request unless `c_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| c_valid | input | 1 | CPU request valid |
| c_ready | output | 1 | CPU request complete this cycle |
| c_we | input | 1 | 1 = write, 0 = read |
| c_size | input | 2 | Width code: 0 byte, 1 half, 2 word |
| c_addr | input | 32 | Byte address |
| c_wdata | input | 32 | Right-aligned write data |
| c_rdata | output | 32 | Right-aligned read data, valid with c_ready |
| s_valid | output | 1 | Sound halfword request valid |
| s_ready | input | 1 | Sound transaction accepted |
| s_we | output | 1 | Sound write enable |
| s_addr | output | 32 | Sound halfword address (masked, even) |
| s_wdata | output | 16 | Sound write data |
| s_rdata | input | 16 | Sound read data, valid with s_ready |
| t_valid | output | 1 | Timer request valid |
| t_ready | input | 1 | Timer transaction accepted |
| t_we | output | 1 | Timer write enable |
| t_idx | output | 2 | Timer slot number |
| t_reg | output | 2 | Register: 0 count, 1 mode, 2 target |
| t_wdata | output | 32 | Timer write data |
| t_rdata | input | 32 | Timer read data |

## Verification
The assertions check the following on every cycle:
- addresses sent to the sound port are masked and even;
- the sound and timer ports never request together, and neither requests without a CPU request;
- a stalled sound transaction holds the CPU ready low;
- a completed first half is followed by a second half at the address plus 2 carrying the upper data half;
- byte writes reach the sound port zero-extended;
- count and target writes reach the timer port cut to 16 bits.

Only the bench scenarios can show the rest:
- the window boundary addresses;
- dropped odd byte writes and their immediate completion;
- the assembly of split reads;
- little-endian lane merging in the local store;
- the decode of timer slot and register numbers.

// File: rtl/periph_width_bridge.sv
module periph_width_bridge #(
  parameter logic [31:0] ADDR_MASK   = 32'h1FFF_FFFF,
  parameter logic [31:0] SND_LO      = 32'h1F80_1C00,
  parameter logic [31:0] SND_HI      = 32'h1F80_2000,
  parameter logic [31:0] TMR_BASE    = 32'h1F80_1100,
  parameter int          NUM_TMR     = 3,
  parameter int          TMR_STRIDE  = 16,
  parameter int          LOCAL_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        c_valid,
  output logic        c_ready,
  input  logic        c_we,
  input  logic [1:0]  c_size,
  input  logic [31:0] c_addr,
  input  logic [31:0] c_wdata,
  output logic [31:0] c_rdata,
  output logic        s_valid,
  input  logic        s_ready,
  output logic        s_we,
  output logic [31:0] s_addr,
  output logic [15:0] s_wdata,
  input  logic [15:0] s_rdata,
  output logic        t_valid,
  input  logic        t_ready,
  output logic        t_we,
  output logic [1:0]  t_idx,
  output logic [1:0]  t_reg,
  output logic [31:0] t_wdata,
  input  logic [31:0] t_rdata
);
  localparam int LW        = $clog2(LOCAL_WORDS);
  localparam int SLOT_BITS = $clog2(TMR_STRIDE);
  localparam logic [31:0] TMR_END = TMR_BASE + 32'(NUM_TMR * TMR_STRIDE);

  logic [31:0] a;
  logic        is_byte, is_word;
  logic        hit_snd, in_tmr, hit_tmr, hit_loc, drop;
  logic [31:0] toff;
  logic [SLOT_BITS-1:0] roff;
  logic        phase;
  logic [15:0] lo_q;
  logic        snd_done;

  assign a       = c_addr & ADDR_MASK;
  assign is_byte = (c_size == 2'd0);
  assign is_word = c_size[1];

  assign hit_snd = (a >= SND_LO) && (a < SND_HI);
  assign toff    = a - TMR_BASE;
  assign roff    = toff[SLOT_BITS-1:0];
  assign in_tmr  = (a >= TMR_BASE) && (a < TMR_END);
  assign hit_tmr = !hit_snd && in_tmr && !is_byte &&
                   (roff == SLOT_BITS'(0) || roff == SLOT_BITS'(4) || roff == SLOT_BITS'(8));
  assign hit_loc = !hit_snd && !hit_tmr;
  assign drop    = hit_snd && c_we && is_byte && a[0];

  // sound port: halfword only, word accesses split in two phases
  assign s_valid = c_valid && hit_snd && !drop;
  assign s_we    = c_we;
  assign s_addr  = {a[31:1], 1'b0} + (phase ? 32'd2 : 32'd0);
  always_comb begin
    if (is_word)      s_wdata = phase ? c_wdata[31:16] : c_wdata[15:0];
    else if (is_byte) s_wdata = {8'h00, c_wdata[7:0]};
    else              s_wdata = c_wdata[15:0];
  end
  assign snd_done = drop || (s_ready && (!is_word || phase));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      lo_q  <= '0;
    end else if (s_valid && s_ready && is_word) begin
      phase <= !phase;
      if (!phase) lo_q <= s_rdata;
    end
  end

  // timer port: count and target are 16-bit
  assign t_valid = c_valid && hit_tmr;
  assign t_we    = c_we;
  assign t_idx   = 2'(toff[SLOT_BITS +: 2]);
  assign t_reg   = roff[3:2];
  assign t_wdata = (t_reg == 2'd1) ? c_wdata : {16'h0000, c_wdata[15:0]};

  // local backing store, little-endian lanes
  logic [31:0] mem [LOCAL_WORDS];
  logic [LW-1:0] widx;
  logic [3:0]  be;
  logic [31:0] lane_data, loc_word, loc_sh, loc_rd;

  assign widx = a[LW+1:2];
  always_comb begin
    case (c_size)
      2'd0:    begin be = 4'b0001 << a[1:0];        lane_data = {4{c_wdata[7:0]}};  end
      2'd1:    begin be = a[1] ? 4'b1100 : 4'b0011; lane_data = {2{c_wdata[15:0]}}; end
      default: begin be = 4'b1111;                  lane_data = c_wdata;            end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LOCAL_WORDS; i++) mem[i] <= '0;
    end else if (c_valid && hit_loc && c_we) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) mem[widx][8*b +: 8] <= lane_data[8*b +: 8];
    end
  end

  assign loc_word = mem[widx];
  assign loc_sh   = loc_word >> {a[1:0], 3'b000};
  always_comb begin
    case (c_size)
      2'd0:    loc_rd = {24'h0, loc_sh[7:0]};
      2'd1:    loc_rd = {16'h0, loc_sh[15:0]};
      default: loc_rd = loc_word;
    endcase
  end

  // CPU-side response
  assign c_ready = hit_snd ? snd_done : (hit_tmr ? t_ready : 1'b1);
  always_comb begin
    if (hit_snd) begin
      if (is_word)      c_rdata = {s_rdata, lo_q};
      else if (is_byte) c_rdata = {24'h0, a[0] ? s_rdata[15:8] : s_rdata[7:0]};
      else              c_rdata = {16'h0, s_rdata};
    end else if (hit_tmr) begin
      c_rdata = is_word ? t_rdata : {16'h0, t_rdata[15:0]};
    end else begin
      c_rdata = loc_rd;
    end
  end
endmodule

// File: rtl/periph_width_bridge_chk.sv
module periph_width_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        c_valid,
  input logic        c_ready,
  input logic [1:0]  c_size,
  input logic [31:0] c_wdata,
  input logic        s_valid,
  input logic        s_ready,
  input logic        s_we,
  input logic [31:0] s_addr,
  input logic [15:0] s_wdata,
  input logic        t_valid,
  input logic        t_we,
  input logic [1:0]  t_reg,
  input logic [31:0] t_wdata
);
  AST_SND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> (s_addr[31:29] == 3'b000 && !s_addr[0])); // R1
  AST_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !c_ready) |=>
      (s_valid && s_addr == $past(s_addr) + 32'd2 && s_wdata == $past(c_wdata[31:16]))); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |-> !c_ready); // R5
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_we && c_size == 2'd0) |-> s_wdata[15:8] == 8'h00); // R6
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && t_valid)); // R7
  AST_TMR_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    (t_valid && t_we && t_reg != 2'd1) |-> t_wdata[31:16] == 16'h0000); // R8
  AST_NO_STRAY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !c_valid |-> (!s_valid && !t_valid)); // R10
endmodule

bind periph_width_bridge periph_width_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .c_valid(c_valid), .c_ready(c_ready),
  .c_size(c_size), .c_wdata(c_wdata), .s_valid(s_valid), .s_ready(s_ready),
  .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .t_valid(t_valid),
  .t_we(t_we), .t_reg(t_reg), .t_wdata(t_wdata)
);

// File: tb/periph_width_bridge_test.sv
`timescale 1ns/1ps
module periph_width_bridge_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        c_valid = 0, c_we = 0, c_ready;
  logic [1:0]  c_size = 0;
  logic [31:0] c_addr = 0, c_wdata = 0, c_rdata;
  logic        s_valid, s_ready, s_we;
  logic [31:0] s_addr;
  logic [15:0] s_wdata, s_rdata;
  logic        t_valid, t_ready, t_we;
  logic [1:0]  t_idx, t_reg;
  logic [31:0] t_wdata, t_rdata;

  logic stall = 0;
  logic [7:0] cyc = 0;
  always @(posedge clk) cyc <= cyc + 8'd1;
  assign s_ready = stall ? cyc[0] & cyc[1] : 1'b1;
  assign s_rdata = s_addr[15:0] ^ 16'hA5A5;
  assign t_ready = 1'b1;
  assign t_rdata = {16'hC0DE, 10'h0, t_idx, 2'b00, t_reg};

  periph_width_bridge uut (.*);

  int total = 0, bad = 0;
  int sn = 0, tn = 0;
  logic [31:0] s_log_a [16];
  logic [15:0] s_log_d [16];
  logic [1:0]  t_log_i [16];
  logic [1:0]  t_log_r [16];
  logic [31:0] t_log_d [16];
  always @(posedge clk) begin
    if (s_valid && s_ready && s_we && sn < 16) begin
      s_log_a[sn] <= s_addr; s_log_d[sn] <= s_wdata; sn <= sn + 1;
    end
    if (t_valid && t_ready && t_we && tn < 16) begin
      t_log_i[tn] <= t_idx; t_log_r[tn] <= t_reg; t_log_d[tn] <= t_wdata; tn <= tn + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] ad,
                        input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    c_valid = 1; c_we = we; c_size = sz; c_addr = ad; c_wdata = wd;
    waits = 0; rd = '0;
    forever begin
      #1;
      if (c_ready) begin rd = c_rdata; break; end
      waits++;
      if (waits > 50) begin
        total++; bad++;
        $display("FAIL access hang at %h actual=0 expected=1", ad);
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
    #0.5;
    c_valid = 0;
  endtask

  logic [31:0] rd;
  int w;

  task automatic t_reset();
    access(0, 2'd2, 32'h1F80_0040, 0, rd, w);
    check("R10 local store zero after reset", rd, 32'h0);
  endtask

  task automatic t_local();
    access(1, 2'd2, 32'h1F80_0010, 32'h1122_3344, rd, w);
    access(0, 2'd0, 32'h1F80_0011, 0, rd, w);
    check("R9 byte read lane1", rd, 32'h33);
    access(0, 2'd1, 32'h1F80_0012, 0, rd, w);
    check("R9 half read upper", rd, 32'h1122);
    access(1, 2'd0, 32'h1F80_0013, 32'hFFFF_FFAB, rd, w);
    access(0, 2'd2, 32'h1F80_0010, 0, rd, w);
    check("R9 byte write merges one lane", rd, 32'hAB22_3344);
    access(1, 2'd1, 32'h1F80_0010, 32'h0000_BEEF, rd, w);
    access(0, 2'd2, 32'h1F80_0010, 0, rd, w);
    check("R9 half write low lanes", rd, 32'hAB22_BEEF);
  endtask

  task automatic t_mask();
    int n0;
    access(1, 2'd2, 32'hBF80_0020, 32'hCAFE_F00D, rd, w);
    access(0, 2'd2, 32'h1F80_0020, 0, rd, w);
    check("R1 masked local alias", rd, 32'hCAFE_F00D);
    n0 = sn;
    access(1, 2'd1, 32'h9F80_1C10, 32'h0000_1234, rd, w);
    check("R1 sound count", 32'(sn - n0), 32'd1);
    check("R1 sound addr masked", s_log_a[n0], 32'h1F80_1C10);
  endtask

  task automatic t_bounds();
    int n0;
    n0 = sn;
    access(1, 2'd1, 32'h1F80_1BFE, 32'h0000_0101, rd, w);
    check("R2 below window not sound", 32'(sn - n0), 32'd0);
    access(0, 2'd1, 32'h1F80_1BFE, 0, rd, w);
    check("R2 below window local", rd, 32'h0101);
    access(1, 2'd1, 32'h1F80_1C00, 32'h0000_0202, rd, w);
    access(1, 2'd1, 32'h1F80_1FFE, 32'h0000_0303, rd, w);
    check("R2 window edges sound", 32'(sn - n0), 32'd2);
    check("R2 last addr", s_log_a[n0+1], 32'h1F80_1FFE);
    access(1, 2'd1, 32'h1F80_2000, 32'h0000_0404, rd, w);
    check("R2 end excluded", 32'(sn - n0), 32'd2);
  endtask

  task automatic t_split_write();
    int n0;
    n0 = sn; stall = 1;
    access(1, 2'd2, 32'h1F80_1C20, 32'hDEAD_BEEF, rd, w);
    stall = 0;
    check("R3 two halves", 32'(sn - n0), 32'd2);
    check("R3 first addr", s_log_a[n0], 32'h1F80_1C20);
    check("R3 first data", {16'h0, s_log_d[n0]}, 32'hBEEF);
    check("R3 second addr", s_log_a[n0+1], 32'h1F80_1C22);
    check("R3 second data", {16'h0, s_log_d[n0+1]}, 32'hDEAD);
    check("R5 ready held while stalled", 32'(w > 1), 32'd1);
  endtask

  task automatic t_split_read();
    stall = 1;
    access(0, 2'd2, 32'h1F80_1C40, 0, rd, w);
    stall = 0;
    check("R4 assembled read", rd, {16'h1C42 ^ 16'hA5A5, 16'h1C40 ^ 16'hA5A5});
    access(0, 2'd1, 32'h1F80_1C46, 0, rd, w);
    check("R4 half read pass", rd, {16'h0, 16'h1C46 ^ 16'hA5A5});
  endtask

  task automatic t_byte_snd();
    int n0;
    logic [15:0] hv;
    n0 = sn;
    access(1, 2'd0, 32'h1F80_1C31, 32'h0000_0077, rd, w);
    check("R6 odd byte dropped", 32'(sn - n0), 32'd0);
    check("R6 odd byte immediate", 32'(w), 32'd0);
    access(1, 2'd0, 32'h1F80_1C30, 32'hFFFF_FF5A, rd, w);
    check("R6 even byte forwarded", 32'(sn - n0), 32'd1);
    check("R6 even byte data", {16'h0, s_log_d[n0]}, 32'h005A);
    hv = 16'h1C34 ^ 16'hA5A5;
    access(0, 2'd0, 32'h1F80_1C35, 0, rd, w);
    check("R6 byte read high", rd, {24'h0, hv[15:8]});
  endtask

  task automatic t_timer();
    int n0;
    n0 = tn;
    access(1, 2'd2, 32'h1F80_1118, 32'h1234_5678, rd, w);
    access(1, 2'd2, 32'h1F80_1124, 32'h1234_5678, rd, w);
    access(1, 2'd1, 32'h1F80_1100, 32'h0000_BEEF, rd, w);
    check("R7 three timer writes", 32'(tn - n0), 32'd3);
    check("R7 slot1 target", {28'h0, t_log_i[n0], t_log_r[n0]}, 32'h6);
    check("R8 target truncated", t_log_d[n0], 32'h0000_5678);
    check("R7 slot2 mode", {28'h0, t_log_i[n0+1], t_log_r[n0+1]}, 32'h9);
    check("R8 mode full width", t_log_d[n0+1], 32'h1234_5678);
    check("R8 count half", t_log_d[n0+2], 32'h0000_BEEF);
    access(0, 2'd2, 32'h1F80_1114, 0, rd, w);
    check("R7 timer read slot1 mode", rd, 32'hC0DE_0011);
    n0 = tn;
    access(1, 2'd0, 32'h1F80_1100, 32'h0000_0099, rd, w);
    access(1, 2'd1, 32'h1F80_110C, 32'h0000_4321, rd, w);
    check("R7 byte and offset C not timer", 32'(tn - n0), 32'd0);
    access(0, 2'd0, 32'h1F80_1100, 0, rd, w);
    check("R7 byte went local", rd, 32'h99);
    access(0, 2'd1, 32'h1F80_110C, 0, rd, w);
    check("R7 offset C went local", rd, 32'h4321);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_local();
    t_mask();
    t_bounds();
    t_split_write();
    t_split_read();
    t_byte_snd();
    t_timer();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule